// File: doc/BRIEF.md
# Energy-Bin Event Counter Bank with Frame Readout

This block holds the event counts of a group of detector channels, eight energy bins per channel. A pulse classifier in front of it raises at most one bin strobe per channel per clock; the matching 8-bit counter steps once. The counters step through a maximal-length shift-register sequence rather than a binary one, so each step costs only a short XOR tree. Decoding to binary happens off-chip. Each channel also keeps two sticky status bits: one marks a counter that wrapped, and one marks a malformed comparator pattern reported by the classifier.

A frame request copies every counter, both status bits and two computed parity bits into a shift register that serves as the holding buffer. In the same cycle it restarts all counters at the seed value, so acquisition of the next frame runs while the previous frame is shifted out. Each channel yields a 68-bit record. The records leave on two lanes, two bits per lane per clock (one for the rising half, one for the falling half), so four bits move per clock. The physical double-rate drivers sit outside the block.

Top module: `lfsr_bin_bank`

## Requirements
- R1: A strobe on a bin advances that counter by one step of the sequence next = {q[6:0], q[7]^q[5]^q[4]^q[3]} (polynomial x^8+x^6+x^5+x^4+1). The counter starts at 8'h01 after reset and never holds 8'h00, so it has 255 states.
- R2: If a step would return a counter to 8'h01, the counter wraps to 8'h01 and the channel's wrap status (record bit 64) is set. That bit stays set until the next accepted frame request.
- R3: A pulse on a channel's format-error input sets that channel's format status (record bit 65). That bit stays set until the next accepted frame request.
- R4: Bit ch*8+bin of hit_i steps only counter bin of channel ch. All other counters keep their values.
- R5: An accepted frame request captures the current counters and status, restarts every counter at 8'h01 and clears the status. A strobe or format error in that same cycle is counted in the new frame.
- R6: Record bit 8*b+j of a channel holds bit 7-j of bin b's counter (most significant bit first, bin 0 first). Bits 64 and 65 hold the wrap and format status.
- R7: Record bit 66 is even parity over bins 0 to 3. Record bit 67 is even parity over bins 4 to 7 together with both status bits.
- R8: Stream bit k = ch*68 + record index, channel 0 first. In the t-th cycle after acceptance (t from 0), lane_a_o[1]/lane_a_o[0] carry stream bits 4t and 4t+2, and lane_b_o[1]/lane_b_o[0] carry 4t+1 and 4t+3, with the rising-half bit in bit 1. Both lanes are 0 while idle.
- R9: busy_o is high for exactly N_CH*17 cycles after an accepted request. A request while busy_o is high is ignored and neither restarts the stream nor resets counters.
- R10: Strobes arriving while a readout is in progress are counted into the new frame and do not alter the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | N_CH*8 | One-hot-per-channel bin strobes, bit ch*8+bin |
| fmt_err_i | input | N_CH | Comparator format error pulse per channel |
| frame_req_i | input | 1 | Frame request: snapshot, restart, start readout |
| busy_o | output | 1 | Readout in progress |
| lane_a_o | output | 2 | Lane A: bit 1 rising-half bit, bit 0 falling-half bit |
| lane_b_o | output | 2 | Lane B: bit 1 rising-half bit, bit 0 falling-half bit |

## Verification
The bench builds the block with N_CH = 3. That gives a 204-bit stream of 51 beats, short enough to capture whole and compare record by record, while still crossing two channel boundaries in the shift order. With only three channels, driving 255 strobes into one bin stays cheap, so the wrap back to the seed and the sticky status bit can be reached. Hits during readout, a request on the same cycle as a hit, and a request while busy can all be placed in one frame.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int CNT_W     = 8;
  localparam int N_BINS    = 8;
  localparam int STAT_W    = 2;
  localparam int PAR_W     = 2;
  localparam int DATA_W    = CNT_W * N_BINS;
  localparam int REC_W     = DATA_W + STAT_W + PAR_W;
  localparam int IDX_WRAP  = DATA_W;
  localparam int IDX_FMT   = DATA_W + 1;
  localparam int IDX_PAR0  = DATA_W + 2;
  localparam int IDX_PAR1  = DATA_W + 3;
  localparam int LANE_BITS = 4;
  localparam logic [CNT_W-1:0] SEED = 8'h01;

  // one step of the x^8+x^6+x^5+x^4+1 sequence
  function automatic logic [CNT_W-1:0] lfsr_next(input logic [CNT_W-1:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  function automatic logic even_par(input logic [DATA_W/2+STAT_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/lbc_counter.sv
module lbc_counter
  import lbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] val_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] stepped;

  assign stepped = lfsr_next(val_q);
  assign wrap_o  = inc_i & ~restart_i & (stepped == SEED);
  assign val_o   = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         val_q <= SEED;
    else if (restart_i) val_q <= inc_i ? lfsr_next(SEED) : SEED;
    else if (inc_i)     val_q <= stepped;
  end

  p_never_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    val_q != '0);
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i && !restart_i |=> $stable(val_q));
  p_restart_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i && !inc_i |=> val_q == SEED);
endmodule

// File: rtl/lbc_channel.sv
module lbc_channel
  import lbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [N_BINS-1:0] hit_i,
  input  logic              fmt_i,
  output logic [REC_W-1:0]  rec_o
);
  logic [CNT_W-1:0]  cnt [N_BINS];
  logic [N_BINS-1:0] wrap;
  logic [DATA_W-1:0] cnt_flat;
  logic              any_wrap;
  logic              wrap_q, fmt_q;

  for (genvar b = 0; b < N_BINS; b++) begin : g_bin
    lbc_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_i),
      .inc_i(hit_i[b]), .val_o(cnt[b]), .wrap_o(wrap[b])
    );
    assign cnt_flat[b*CNT_W +: CNT_W] = cnt[b];
  end

  assign any_wrap = |wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
      fmt_q  <= 1'b0;
    end else if (restart_i) begin
      wrap_q <= 1'b0;
      fmt_q  <= fmt_i;
    end else begin
      wrap_q <= wrap_q | any_wrap;
      fmt_q  <= fmt_q | fmt_i;
    end
  end

  always_comb begin
    rec_o = '0;
    for (int b = 0; b < N_BINS; b++)
      for (int j = 0; j < CNT_W; j++)
        rec_o[b*CNT_W + j] = cnt[b][CNT_W-1-j];
    rec_o[IDX_WRAP] = wrap_q;
    rec_o[IDX_FMT]  = fmt_q;
    rec_o[IDX_PAR0] = even_par({{STAT_W{1'b0}}, cnt_flat[DATA_W/2-1:0]});
    rec_o[IDX_PAR1] = even_par({wrap_q, fmt_q, cnt_flat[DATA_W-1:DATA_W/2]});
  end

  p_onehot_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_i));
  p_wrap_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q && !restart_i |=> wrap_q);
  p_wrap_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_wrap |=> wrap_q);
  p_fmt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_i |=> fmt_q);
endmodule

// File: rtl/lbc_serializer.sv
module lbc_serializer
  import lbc_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [N_CH*REC_W-1:0] rec_i,
  output logic                  start_o,
  output logic                  busy_o,
  output logic [1:0]            lane_a_o,
  output logic [1:0]            lane_b_o
);
  localparam int TOT   = N_CH * REC_W;
  localparam int BEATS = TOT / LANE_BITS;
  localparam int BW    = $clog2(BEATS + 1);

  logic [TOT-1:0] sr_q;
  logic [BW-1:0]  beat_q;
  logic           busy_q;
  logic           last_beat;

  assign start_o   = req_i & ~busy_q;
  assign last_beat = busy_q && (beat_q == BW'(BEATS - 1));
  assign busy_o    = busy_q;
  assign lane_a_o  = busy_q ? {sr_q[0], sr_q[2]} : 2'b00;
  assign lane_b_o  = busy_q ? {sr_q[1], sr_q[3]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      beat_q <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      sr_q   <= rec_i;
      beat_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sr_q   <= sr_q >> LANE_BITS;
      beat_q <= beat_q + BW'(1);
      if (last_beat) busy_q <= 1'b0;
    end
  end

  p_req_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last_beat && req_i |=> busy_q && beat_q == $past(beat_q) + BW'(1));
  p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && !req_i |=> !busy_q);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> lane_a_o == 2'b00 && lane_b_o == 2'b00);
endmodule

// File: rtl/lfsr_bin_bank.sv
module lfsr_bin_bank
  import lbc_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH*N_BINS-1:0] hit_i,
  input  logic [N_CH-1:0]        fmt_err_i,
  input  logic                   frame_req_i,
  output logic                   busy_o,
  output logic [1:0]             lane_a_o,
  output logic [1:0]             lane_b_o
);
  logic                  restart;
  logic [N_CH*REC_W-1:0] rec_all;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    lbc_channel u_ch (
      .clk(clk), .rst_n(rst_n), .restart_i(restart),
      .hit_i(hit_i[c*N_BINS +: N_BINS]), .fmt_i(fmt_err_i[c]),
      .rec_o(rec_all[c*REC_W +: REC_W])
    );
  end

  lbc_serializer #(.N_CH(N_CH)) u_ser (
    .clk(clk), .rst_n(rst_n), .req_i(frame_req_i), .rec_i(rec_all),
    .start_o(restart), .busy_o(busy_o),
    .lane_a_o(lane_a_o), .lane_b_o(lane_b_o)
  );

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> busy_o);
endmodule

// File: tb/test_lfsr_bin_bank.sv
module test_lfsr_bin_bank;
  localparam int NC = 3;
  localparam int RW = 68;
  localparam int SW = NC * RW;
  localparam int NB = SW / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC*8-1:0] hit = '0;
  logic [NC-1:0] fmt = '0;
  logic frame_req = 1'b0;
  logic busy;
  logic [1:0] la, lb;

  always #5 clk = ~clk;

  lfsr_bin_bank #(.N_CH(NC)) i_lfsr_bin_bank (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .fmt_err_i(fmt),
    .frame_req_i(frame_req), .busy_o(busy), .lane_a_o(la), .lane_b_o(lb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cnt_m [NC][8];
  bit wrap_m [NC];
  bit fmt_m [NC];

  // {ch[1:0], bin[2:0], is_fmt, n[9:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 3'd0, 1'b0, 10'd5},
    {2'd0, 3'd3, 1'b0, 10'd1},
    {2'd1, 3'd7, 1'b0, 10'd20},
    {2'd2, 3'd2, 1'b0, 10'd255},
    {2'd1, 3'd0, 1'b1, 10'd0},
    {2'd2, 3'd5, 1'b0, 10'd254},
    {2'd0, 3'd7, 1'b0, 10'd3},
    {2'd1, 3'd2, 1'b0, 10'd9}
  };

  function automatic logic [7:0] seq_val(input int n);
    logic [7:0] v = 8'h01;
    for (int i = 0; i < n % 255; i++) v = {v[6:0], ^(v & 8'hB8)};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model_hit(input int idx);
    cnt_m[idx/8][idx%8]++;
    if (cnt_m[idx/8][idx%8] % 255 == 0) wrap_m[idx/8] = 1;
  endtask

  task automatic send_hits(input int ch, input int bin, input int n);
    for (int i = 0; i < n; i++) begin
      hit = '0; hit[ch*8+bin] = 1'b1;
      model_hit(ch*8+bin);
      @(negedge clk);
    end
    hit = '0;
  endtask

  task automatic send_fmt(input int ch);
    fmt = '0; fmt[ch] = 1'b1; fmt_m[ch] = 1;
    @(negedge clk);
    fmt = '0;
  endtask

  function automatic logic [SW-1:0] build_exp();
    logic [SW-1:0] e = '0;
    for (int c = 0; c < NC; c++) begin
      int p0 = 0, p1 = 0;
      for (int b = 0; b < 8; b++) begin
        logic [7:0] v = seq_val(cnt_m[c][b]);
        for (int j = 0; j < 8; j++) e[c*RW + 8*b + j] = v[7-j];
        if (b < 4) p0 += $countones(v); else p1 += $countones(v);
      end
      e[c*RW+64] = wrap_m[c];
      e[c*RW+65] = fmt_m[c];
      e[c*RW+66] = p0[0];
      e[c*RW+67] = p1[0] ^ wrap_m[c] ^ fmt_m[c];
    end
    return e;
  endfunction

  task automatic readout(input string tag, input int req_idx, input int dur_idx,
                         input int dur_n, input bit poke);
    logic [SW-1:0] e, s;
    e = build_exp();
    for (int c = 0; c < NC; c++) begin
      wrap_m[c] = 0; fmt_m[c] = 0;
      for (int b = 0; b < 8; b++) cnt_m[c][b] = 0;
    end
    @(negedge clk);
    frame_req = 1'b1; hit = '0;
    if (req_idx >= 0) begin hit[req_idx] = 1'b1; model_hit(req_idx); end
    @(negedge clk);
    frame_req = 1'b0; hit = '0;
    s = '0;
    for (int t = 0; t < NB; t++) begin
      s[4*t] = la[1]; s[4*t+2] = la[0]; s[4*t+1] = lb[1]; s[4*t+3] = lb[0];
      if (t == 0) chk({tag, " R9 busy after accept"}, busy, 1);
      hit = '0;
      if (dur_idx >= 0 && t < dur_n) begin hit[dur_idx] = 1'b1; model_hit(dur_idx); end
      frame_req = poke && (t == 5);
      @(negedge clk);
    end
    hit = '0; frame_req = 1'b0;
    chk({tag, " R9 busy drops after last beat"}, busy, 0);
    chk({tag, " R8 idle lanes"}, {la, lb}, 0);
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < 8; b++)
        chk($sformatf("%s R1 R4 R6 ch%0d bin%0d", tag, c, b),
            s[c*RW+8*b +: 8], e[c*RW+8*b +: 8]);
      chk($sformatf("%s R2 wrap ch%0d", tag, c), s[c*RW+64], e[c*RW+64]);
      chk($sformatf("%s R3 fmt ch%0d", tag, c), s[c*RW+65], e[c*RW+65]);
      chk($sformatf("%s R7 parity ch%0d", tag, c), s[c*RW+66 +: 2], e[c*RW+66 +: 2]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      wrap_m[c] = 0; fmt_m[c] = 0;
      for (int b = 0; b < 8; b++) cnt_m[c][b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R9 busy low", busy, 0);
    chk("reset R8 lanes quiet", {la, lb}, 0);

    foreach (VEC[i]) begin
      if (VEC[i][10]) send_fmt(int'(VEC[i][15:14]));
      else send_hits(int'(VEC[i][15:14]), int'(VEC[i][13:11]), int'(VEC[i][9:0]));
    end

    // frame 1: table data; hit on accept cycle, hits and a request during readout
    readout("F1", 0*8+6, 1*8+4, 10, 1'b1);
    // frame 2: holds only the accept-cycle hit and the in-readout hits
    readout("F2 R5 R10", -1, -1, 0, 1'b0);
    // frame 3: everything at seed after restart
    readout("F3 R5", -1, -1, 0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule